// File: doc/BRIEF.md
# Memory-mapped serial transmitter

This block is a transmit-only asynchronous serial port that hangs off an 8-bit processor memory bus with a 16-bit address. Software writes a byte to the transmit address. If the port is idle, it latches the byte and sends one frame on a single output line. A frame is a low start bit, then eight data bits with the least significant bit first, then a high stop bit. Every bit lasts a fixed number of clock cycles, which is set by a parameter.

A status address returns the busy flag in bit 0. Software polls it and writes the next byte only after the flag reads 0. The bus uses single-cycle strobes. A write is captured in the cycle its strobe is high. A read is answered in the cycle after its strobe, and the answer is held for exactly that one cycle.

Top module: `mmio_serial_tx`

## Requirements
- R1: After reset the serial line is high, the read data bus is 0 and the port is idle.
- R2: A write strobe with address 0xFFFF while the port is idle latches the write data and starts a frame. The line goes low in the cycle after that strobe's clock edge and stays low for CLKS_PER_BIT cycles (the start bit).
- R3: The start bit is followed by the eight data bits, least significant bit first. Each data bit lasts CLKS_PER_BIT cycles, and the line carries the value of that bit.
- R4: After the last data bit the line is high for CLKS_PER_BIT cycles (the stop bit). It then stays high while idle. A write in the first cycle after the stop bit ends starts a new frame.
- R5: A read strobe with address 0xFFFE returns, on the read data bus in the next cycle only, the busy flag as it was at the strobe edge. Bit 0 is 1 for busy, and bits 7..1 are 0. In every cycle that does not follow such a strobe, the read data bus is 0.
- R6: The busy flag reads 1 from the cycle after an accepted write until the stop bit has finished (10*CLKS_PER_BIT cycles). It reads 0 after that.
- R7: A write to 0xFFFF while busy is ignored. The frame in progress continues unchanged, and no further frame follows it.
- R8: A write to any address other than 0xFFFF starts nothing. A read of any address other than 0xFFFE returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 16 | Bus address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | One-cycle write strobe |
| bus_rd | input | 1 | One-cycle read strobe |
| bus_rdata | output | 8 | Read data, valid the cycle after a read strobe |
| tx_line | output | 1 | Serial output, idle high |

## Verification
If a write is accepted at clock edge k, the line carries frame bit j between edges k+j*CLKS_PER_BIT and k+(j+1)*CLKS_PER_BIT, and the port is idle again from edge k+10*CLKS_PER_BIT. A status read strobed at edge r is visible only between edges r and r+1. The bench drives inputs and samples outputs on falling edges. It counts frame cycles from the write edge and compares the line against the bit that this arithmetic predicts for every cycle of every frame. It checks each read answer in the single cycle it is due and checks that the bus is back to 0 in the cycle after.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_START = 2'd1,
        ST_DATA  = 2'd2,
        ST_STOP  = 2'd3
    } frame_state_e;
endpackage

// File: rtl/sertx_bus_port.sv
module sertx_bus_port #(
    parameter int          ADDR_W    = 16,
    parameter int          DATA_W    = 8,
    parameter logic [15:0] TX_ADDR   = 16'hFFFF,
    parameter logic [15:0] STAT_ADDR = 16'hFFFE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic              busy,
    output logic              load,
    output logic [DATA_W-1:0] load_byte,
    output logic [DATA_W-1:0] bus_rdata
);
    typedef struct packed {
        logic [DATA_W-1:0] rdata;
    } port_reg_t;

    port_reg_t r_q, r_d;
    logic      rd_stat;

    always_comb begin
        r_d       = r_q;
        rd_stat   = bus_rd && (bus_addr == ADDR_W'(STAT_ADDR));
        load      = bus_wr && (bus_addr == ADDR_W'(TX_ADDR)) && !busy;
        load_byte = bus_wdata;
        if (rd_stat) begin
            r_d.rdata = {{(DATA_W-1){1'b0}}, busy};
        end else begin
            r_d.rdata = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign bus_rdata = r_q.rdata;

    // R5
    rdata_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rd_stat) |-> (bus_rdata == '0));

    // R5
    rdata_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stat |=> (bus_rdata[0] == $past(busy)));
endmodule

// File: rtl/sertx_baud_timer.sv
module sertx_baud_timer #(
    parameter int CLKS_PER_BIT = 4,
    localparam int CNT_W = (CLKS_PER_BIT > 1) ? $clog2(CLKS_PER_BIT) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic run,
    output logic bit_end
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } timer_reg_t;

    timer_reg_t t_q, t_d;
    logic       at_last;

    always_comb begin
        t_d     = t_q;
        at_last = (t_q.cnt == CNT_W'(CLKS_PER_BIT - 1));
        bit_end = run && at_last && !restart;
        if (restart) begin
            t_d.cnt = '0;
        end else if (run) begin
            t_d.cnt = at_last ? '0 : t_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            t_q <= '0;
        end else begin
            t_q <= t_d;
        end
    end

    // R3
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        t_q.cnt <= CNT_W'(CLKS_PER_BIT - 1));

    // R2
    restart_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (t_q.cnt == '0));
endmodule

// File: rtl/sertx_frame_fsm.sv
module sertx_frame_fsm
    import sertx_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_byte,
    input  logic              bit_end,
    output logic              busy,
    output logic              tx
);
    typedef struct packed {
        frame_state_e      state;
        logic [DATA_W-1:0] sh;
        logic [IDX_W-1:0]  idx;
        logic              tx;
    } fsm_reg_t;

    fsm_reg_t f_q, f_d;

    always_comb begin
        f_d = f_q;
        unique case (f_q.state)
            ST_IDLE: begin
                f_d.tx = 1'b1;
                if (load) begin
                    f_d.state = ST_START;
                    f_d.sh    = load_byte;
                    f_d.tx    = 1'b0;
                end
            end
            ST_START: begin
                if (bit_end) begin
                    f_d.state = ST_DATA;
                    f_d.idx   = '0;
                    f_d.tx    = f_q.sh[0];
                end
            end
            ST_DATA: begin
                if (bit_end) begin
                    if (f_q.idx == IDX_W'(DATA_W - 1)) begin
                        f_d.state = ST_STOP;
                        f_d.tx    = 1'b1;
                    end else begin
                        f_d.idx = f_q.idx + 1'b1;
                        f_d.sh  = f_q.sh >> 1;
                        f_d.tx  = f_q.sh[1];
                    end
                end
            end
            ST_STOP: begin
                if (bit_end) begin
                    f_d.state = ST_IDLE;
                    f_d.tx    = 1'b1;
                end
            end
            default: f_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            f_q.state <= ST_IDLE;
            f_q.sh    <= '0;
            f_q.idx   <= '0;
            f_q.tx    <= 1'b1;
        end else begin
            f_q <= f_d;
        end
    end

    assign busy = (f_q.state != ST_IDLE);
    assign tx   = f_q.tx;

    // R2
    start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !busy) |=> (!tx && busy));

    // R4
    idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (f_q.state == ST_IDLE) |-> tx);

    // R3
    hold_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !bit_end) |=> $stable(tx));
endmodule

// File: rtl/mmio_serial_tx.sv
module mmio_serial_tx #(
    parameter int          ADDR_W       = 16,
    parameter int          DATA_W       = 8,
    parameter int          CLKS_PER_BIT = 4,
    parameter logic [15:0] TX_ADDR      = 16'hFFFF,
    parameter logic [15:0] STAT_ADDR    = 16'hFFFE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              tx_line
);
    logic              busy;
    logic              load;
    logic [DATA_W-1:0] load_byte;
    logic              bit_end;

    sertx_bus_port #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .TX_ADDR  (TX_ADDR),
        .STAT_ADDR(STAT_ADDR)
    ) u_port (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_wr   (bus_wr),
        .bus_rd   (bus_rd),
        .busy     (busy),
        .load     (load),
        .load_byte(load_byte),
        .bus_rdata(bus_rdata)
    );

    sertx_baud_timer #(
        .CLKS_PER_BIT(CLKS_PER_BIT)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .restart(load),
        .run    (busy),
        .bit_end(bit_end)
    );

    sertx_frame_fsm #(
        .DATA_W(DATA_W)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_byte(load_byte),
        .bit_end  (bit_end),
        .busy     (busy),
        .tx       (tx_line)
    );

    // R7
    no_load_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !load);
endmodule

// File: tb/mmio_serial_tx_test.sv
module mmio_serial_tx_test;
    localparam int N     = 4;
    localparam int FRAME = 10 * N;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr = 16'h0000;
    logic [7:0]  bus_wdata = 8'h00;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_rdata;
    logic        tx_line;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    mmio_serial_tx #(.CLKS_PER_BIT(N)) uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_wr   (bus_wr),
        .bus_rd   (bus_rd),
        .bus_rdata(bus_rdata),
        .tx_line  (tx_line)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic frame_bit(input logic [7:0] b, input int j);
        if (j == 0) return 1'b0;
        if (j == 9) return 1'b1;
        return b[j-1];
    endfunction

    // Send byte b; sample every frame cycle. Optional mid-frame write of
    // another byte and a status read, plus a read of the transmit address.
    task automatic send_frame(input logic [7:0] b, input bit inject,
                              input logic [7:0] other);
        int bad = 0;
        logic act_bad = 1'b0;
        logic exp_bad = 1'b0;
        bus_addr  = 16'hFFFF;
        bus_wdata = b;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        for (int m = 0; m < FRAME; m++) begin
            if (m > 0) @(negedge clk);
            bus_wr = 1'b0;
            bus_rd = 1'b0;
            if (tx_line !== frame_bit(b, m / N)) begin
                if (bad == 0) begin
                    act_bad = tx_line;
                    exp_bad = frame_bit(b, m / N);
                end
                bad++;
            end
            if (inject && m == 3 * N) begin
                bus_addr  = 16'hFFFF;
                bus_wdata = other;
                bus_wr    = 1'b1;
            end
            if (inject && m == 5 * N) begin
                bus_addr = 16'hFFFE;
                bus_rd   = 1'b1;
            end
            if (inject && m == 5 * N + 1) begin
                check("R5 status busy", bus_rdata, 8'h01);
            end
            if (inject && m == 5 * N + 2) begin
                check("R5 rdata cleared", bus_rdata, 8'h00);
                bus_addr = 16'hFFFF;
                bus_rd   = 1'b1;
            end
            if (inject && m == 5 * N + 3) begin
                check("R8 read other addr", bus_rdata, 8'h00);
            end
            if (m == FRAME - 2) begin
                bus_addr = 16'hFFFE;
                bus_rd   = 1'b1;
            end
            if (m == FRAME - 1) begin
                check("R6 busy last cycle", bus_rdata, 8'h01);
            end
        end
        checks++;
        if (bad != 0) begin
            failures++;
            $display("FAIL R2/R3/R4 frame %0h actual=%0b expected=%0b", b, act_bad, exp_bad);
        end
        @(negedge clk);
        bus_rd = 1'b0;
        check("R4 idle high", {7'b0, tx_line}, 8'h01);
    endtask

    task automatic idle_window(input string req, input int cycles);
        int bad = 0;
        for (int m = 0; m < cycles; m++) begin
            @(negedge clk);
            bus_wr = 1'b0;
            if (tx_line !== 1'b1) bad++;
        end
        check(req, 8'(bad), 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1
        check("R1 tx reset", {7'b0, tx_line}, 8'h01);
        check("R1 rdata reset", bus_rdata, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);

        // R6: idle status reads 0
        bus_addr = 16'hFFFE;
        bus_rd   = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        check("R6 idle status", bus_rdata, 8'h00);

        // R8: writes to other addresses start nothing
        bus_addr  = 16'hFFFD;
        bus_wdata = 8'h00;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        idle_window("R8 write other addr", FRAME);
        bus_addr  = 16'hFFFE;
        bus_wdata = 8'h00;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        idle_window("R8 write status addr", FRAME);

        // R7: busy write ignored, and no second frame afterwards
        send_frame(8'hA5, 1'b1, 8'h00);
        idle_window("R7 no queued frame", FRAME);
        send_frame(8'h00, 1'b1, 8'hFF);
        send_frame(8'hFF, 1'b1, 8'h00);

        // R2 R3 R4: sweep every byte value back to back
        for (int v = 0; v < 256; v++) begin
            send_frame(8'(v), (v % 17) == 0, 8'(~v));
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int c = 0; c < 150000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule